// File: doc/BRIEF.md
# Time-Slotted Video Memory Arbiter

This block lets a CPU and a video fetch engine share one synchronous memory port. It does this without a dynamic arbiter: every clock is a memory slot, and the slots alternate between the two sides. The video engine owns the even slots and the CPU side owns the odd ones. Either side may leave its slot empty. The sequencer wraps every `RATIO` clocks, which is the number of clocks in one video fetch period. A tick then marks the video slot that opens each period, so fetches land at a fixed phase.

CPU writes go into a one-entry posted buffer. The CPU gets its acknowledge at once and moves on, and the buffer writes itself to memory in the next CPU slot. The CPU waits on a write only when the buffer is still occupied. A read of the address held in the buffer is answered from the buffer. Any other read waits for an empty buffer and a CPU slot, then returns the memory data one cycle later. Video reads return through a registered valid strobe one cycle after issue.

The memory is assumed to be a synchronous RAM whose read data appears the cycle after an enabled read.

Top module: `vmem_slot_arb`

## Requirements
- R1: During the first clock after reset is released, `vid_slot` is 1 (a video slot), the posted buffer is empty, and `cpu_ready`, `vid_rvalid` and `mem_en` are 0 while no request is presented.
- R2: `vid_slot` toggles on every clock. `vid_fetch_tick` is high on one video slot every `RATIO` clocks, and never in a CPU slot.
- R3: `vid_req` in a video slot drives a memory read at `vid_addr` in that cycle (`mem_en`=1, `mem_we`=0). In the next cycle `vid_rvalid` is 1 and `vid_rdata` carries the memory data. `vid_req` in a CPU slot is ignored: there is no memory access and no `vid_rvalid` on the following cycle.
- R4: The memory is written (`mem_we`=1) only in CPU slots, and the CPU side starts memory accesses only in CPU slots.
- R5: A CPU write (`cpu_we`=1) that finds the buffer empty receives `cpu_ready` in the same cycle. It reaches memory as a write to its address in the first CPU slot after that cycle.
- R6: A CPU write that finds the buffer occupied stalls (`cpu_ready`=0) until a CPU slot drains the buffer. In that slot the old entry is written to memory and the new write is accepted with `cpu_ready`=1.
- R7: A CPU read (`cpu_we`=0) of the address held in the posted buffer gets `cpu_ready`=1 in the same cycle, with the buffered data on `cpu_rdata`, in either slot.
- R8: Any other CPU read is issued to memory in the first CPU slot in which the buffer is empty. It completes one cycle later with `cpu_ready`=1 and the memory data on `cpu_rdata`.
- R9: `cpu_ready` is high for exactly one cycle per completed CPU access. A finished read raises no second `cpu_ready` on the cycle that follows it.
- R10: With no CPU request and an empty buffer, the CPU slots leave the memory idle (`mem_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | DW | CPU read data, valid with `cpu_ready` on a read |
| vid_req | input | 1 | Video fetch request, honoured only in video slots |
| vid_addr | input | AW | Video fetch address |
| vid_rvalid | output | 1 | Video data valid, one cycle after issue |
| vid_rdata | output | DW | Video read data |
| vid_slot | output | 1 | 1 in a video slot, 0 in a CPU slot |
| vid_fetch_tick | output | 1 | Marks the video slot that opens each fetch period |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The bench goes after the slot-boundary cases. These are a write that arrives in a video slot versus one that arrives in a CPU slot, and a second write that meets a full buffer one cycle after the first. A design that drained in the wrong slot would show its memory write one cycle early or late. One that let the second write overwrite the buffer would acknowledge it during the stall.

Reads are checked in three situations: a read that hits the buffer, a read that misses with the buffer empty, and a read that misses while the buffer is still full. A bad hit check would return stale memory data or wait needlessly. A miss that overtook the pending write would issue its memory read in the drain slot.

A video request made in a CPU slot must cause no access. A lingering read completion would show up as a second `cpu_ready` pulse.

// File: rtl/vmsa_pkg.sv
package vmsa_pkg;

   // which requester drives the memory port in the current cycle
   typedef enum logic [1:0] {
      MEM_IDLE  = 2'd0,
      MEM_VID   = 2'd1,
      MEM_DRAIN = 2'd2,
      MEM_CPURD = 2'd3
   } mem_owner_e;

   function automatic bit ratio_ok(input int unsigned r);
      return (r >= 2) && ((r % 2) == 0);
   endfunction

endpackage

// File: rtl/vmsa_slot_seq.sv
// Slot sequencer: even phases are video slots, odd phases are CPU slots.
module vmsa_slot_seq #(
   parameter int unsigned RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic vid_slot,
   output logic fetch_tick
);
   localparam int unsigned PW = (RATIO > 2) ? $clog2(RATIO) : 1;

   generate
      if (RATIO == 2) begin : g_toggle
         logic odd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) odd_q <= 1'b0;
            else        odd_q <= ~odd_q;
         end
         assign vid_slot   = ~odd_q;
         assign fetch_tick = ~odd_q;
      end else begin : g_count
         localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
         logic [PW-1:0] phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                phase_q <= '0;
            else if (phase_q == LAST)  phase_q <= '0;
            else                       phase_q <= phase_q + 1'b1;
         end
         assign vid_slot   = ~phase_q[0];
         assign fetch_tick = (phase_q == '0);
      end
   endgenerate
endmodule

// File: rtl/vmsa_wbuf.sv
// One-entry posted write buffer with optional read forwarding.
module vmsa_wbuf #(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 8,
   parameter bit          HIT_FWD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [DW-1:0] load_data,
   input  logic          drain,
   input  logic [AW-1:0] look_addr,
   output logic          valid,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic          hit
);
   logic          valid_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         addr_q  <= load_addr;
         data_q  <= load_data;
      end else if (drain) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign addr  = addr_q;
   assign data  = data_q;

   generate
      if (HIT_FWD) begin : g_fwd
         assign hit = valid_q && (addr_q == look_addr);
      end else begin : g_nofwd
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/vmsa_vid_port.sv
// Video side: issues a read only in its own slot, flags the returning data.
module vmsa_vid_port (
   input  logic clk,
   input  logic rst_n,
   input  logic vid_slot,
   input  logic vid_req,
   output logic issue,
   output logic rvalid
);
   logic rvalid_q;

   assign issue = vid_slot & vid_req;

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= issue;
   end

   assign rvalid = rvalid_q;
endmodule

// File: rtl/vmem_slot_arb.sv
module vmem_slot_arb #(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 8,
   parameter int unsigned RATIO   = 4,
   parameter bit          HIT_FWD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   input  logic          vid_req,
   input  logic [AW-1:0] vid_addr,
   output logic          vid_rvalid,
   output logic [DW-1:0] vid_rdata,
   output logic          vid_slot,
   output logic          vid_fetch_tick,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   import vmsa_pkg::*;

   generate
      if (!ratio_ok(RATIO)) begin : g_bad_ratio
         $error("vmem_slot_arb: RATIO must be even and at least 2");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("vmem_slot_arb: AW and DW must be at least 1");
      end
   endgenerate

   logic          slot_v;
   logic          cpu_slot;
   logic          buf_valid;
   logic [AW-1:0] buf_addr;
   logic [DW-1:0] buf_data;
   logic          buf_hit;
   logic          drain;
   logic          wr_acc;
   logic          rd_want;
   logic          hit_acc;
   logic          rd_issue;
   logic          rd_pend_q;
   logic          vid_issue;
   mem_owner_e    owner;

   vmsa_slot_seq #(.RATIO(RATIO)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .vid_slot   (slot_v),
      .fetch_tick (vid_fetch_tick)
   );

   assign vid_slot = slot_v;
   assign cpu_slot = ~slot_v;

   // CPU side decisions
   assign drain    = cpu_slot & buf_valid;
   assign wr_acc   = cpu_req & cpu_we & ~rd_pend_q & (~buf_valid | drain);
   assign rd_want  = cpu_req & ~cpu_we & ~rd_pend_q;
   assign hit_acc  = rd_want & buf_hit;
   assign rd_issue = rd_want & ~buf_hit & cpu_slot & ~buf_valid;

   vmsa_wbuf #(.AW(AW), .DW(DW), .HIT_FWD(HIT_FWD)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_acc),
      .load_addr (cpu_addr),
      .load_data (cpu_wdata),
      .drain     (drain),
      .look_addr (cpu_addr),
      .valid     (buf_valid),
      .addr      (buf_addr),
      .data      (buf_data),
      .hit       (buf_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_pend_q <= 1'b0;
      else        rd_pend_q <= rd_issue;
   end

   assign cpu_ready = wr_acc | hit_acc | rd_pend_q;
   assign cpu_rdata = rd_pend_q ? mem_rdata : (hit_acc ? buf_data : '0);

   // video side
   vmsa_vid_port u_vid (
      .clk      (clk),
      .rst_n    (rst_n),
      .vid_slot (slot_v),
      .vid_req  (vid_req),
      .issue    (vid_issue),
      .rvalid   (vid_rvalid)
   );

   assign vid_rdata = mem_rdata;

   // memory port mux, one owner per cycle
   always_comb begin
      if (vid_issue)     owner = MEM_VID;
      else if (drain)    owner = MEM_DRAIN;
      else if (rd_issue) owner = MEM_CPURD;
      else               owner = MEM_IDLE;
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (owner)
         MEM_VID: begin
            mem_en   = 1'b1;
            mem_addr = vid_addr;
         end
         MEM_DRAIN: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_addr;
            mem_wdata = buf_data;
         end
         MEM_CPURD: begin
            mem_en   = 1'b1;
            mem_addr = cpu_addr;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vmsa_arb_chk.sv
module vmsa_arb_chk #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_ready,
   input logic          vid_req,
   input logic [AW-1:0] vid_addr,
   input logic          vid_rvalid,
   input logic          vid_slot,
   input logic          vid_fetch_tick,
   input logic          mem_en,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_rdata
);
   a_r1_reset_phase: assert property (@(posedge clk)
      $rose(rst_n) |-> (vid_slot && !vid_rvalid));

   a_r2_to_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      vid_slot |=> !vid_slot);

   a_r2_to_vid: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_slot |=> vid_slot);

   a_r2_tick_slot: assert property (@(posedge clk) disable iff (!rst_n)
      vid_fetch_tick |-> vid_slot);

   a_r3_vid_read: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_slot && vid_req) |-> (mem_en && !mem_we && mem_addr == vid_addr));

   a_r3_vid_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_slot && vid_req) |=> vid_rvalid);

   a_r3_vid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_slot |=> !vid_rvalid);

   a_r4_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !vid_slot);

   a_r8_read_done: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && !vid_slot) |=> cpu_ready);

   a_r10_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (!vid_slot && !cpu_req && mem_en) |-> mem_we);

   logic [DW-1:0] unused_rdata;
   assign unused_rdata = mem_rdata;
endmodule

bind vmem_slot_arb vmsa_arb_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req        (cpu_req),
   .cpu_ready      (cpu_ready),
   .vid_req        (vid_req),
   .vid_addr       (vid_addr),
   .vid_rvalid     (vid_rvalid),
   .vid_slot       (vid_slot),
   .vid_fetch_tick (vid_fetch_tick),
   .mem_en         (mem_en),
   .mem_we         (mem_we),
   .mem_addr       (mem_addr),
   .mem_rdata      (mem_rdata)
);

// File: tb/vmem_slot_arb_test.sv
`timescale 1ns/1ps
module vmem_slot_arb_test;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int RATIO = 4;
   localparam int NV = 12;

   // table entry: {we, addr, data}; data is write data or expected read data
   localparam logic [18:0] VEC [0:NV-1] = '{
      {1'b1, 10'h010, 8'hAA},
      {1'b1, 10'h011, 8'hBB},
      {1'b0, 10'h010, 8'hAA},
      {1'b0, 10'h011, 8'hBB},
      {1'b0, 10'h020, 8'hE3},
      {1'b1, 10'h020, 8'h5C},
      {1'b0, 10'h020, 8'h5C},
      {1'b0, 10'h3FF, 8'hFC},
      {1'b1, 10'h3FF, 8'h01},
      {1'b1, 10'h000, 8'h77},
      {1'b0, 10'h3FF, 8'h01},
      {1'b0, 10'h000, 8'h77}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0, vid_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic vid_req = 1'b0;
   logic cpu_ready, vid_rvalid, vid_slot, vid_fetch_tick, mem_en, mem_we;
   logic [DW-1:0] cpu_rdata, vid_rdata, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] ram [0:(1<<AW)-1];

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vmem_slot_arb #(.AW(AW), .DW(DW), .RATIO(RATIO)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .vid_req(vid_req), .vid_addr(vid_addr), .vid_rvalid(vid_rvalid),
      .vid_rdata(vid_rdata), .vid_slot(vid_slot), .vid_fetch_tick(vid_fetch_tick),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a * 7 + 3);
   endfunction

   initial begin
      for (int i = 0; i < (1 << AW); i++) ram[i] = init_val(i);
   end

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= mem_wdata;
         else        mem_rdata <= ram[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // advance to the next cycle, leaving time to sample after the drive
   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic smp();
      #1;
   endtask

   task automatic to_slot(input bit want);
      do nxt(); while (vid_slot != want);
   endtask

   task automatic idle(input int n);
      cpu_req = 1'b0; vid_req = 1'b0;
      for (int i = 0; i < n; i++) nxt();
   endtask

   task automatic cpu_op(input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
      int waited = 0;
      nxt();
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      smp();
      while (!cpu_ready && waited < 50) begin
         nxt(); smp(); waited++;
      end
      rd = cpu_rdata;
      nxt();
      cpu_req = 1'b0;
      smp();
      chk(!cpu_ready, "R9 single ready", cpu_ready, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      logic prev_slot;
      int last_tick;
      repeat (4) @(posedge clk);
      nxt();
      rst_n = 1'b1;
      // first clock after release: sample before its first active edge
      smp();
      chk(vid_slot == 1'b1, "R1 video phase", vid_slot, 1);
      chk(!cpu_ready && !vid_rvalid && !mem_en, "R1 quiet outputs",
          {cpu_ready, vid_rvalid, mem_en}, 0);

      // R2: alternation and fetch tick spacing
      prev_slot = vid_slot;
      last_tick = 0;
      for (int i = 1; i <= 16; i++) begin
         nxt(); smp();
         chk(vid_slot != prev_slot, "R2 alternate", vid_slot, !prev_slot);
         prev_slot = vid_slot;
         if (vid_fetch_tick) begin
            chk(vid_slot && (i - last_tick == RATIO), "R2 tick spacing",
                i - last_tick, RATIO);
            last_tick = i;
         end
      end

      // table-driven CPU traffic (R5 R6 R7 R8 R9)
      for (int v = 0; v < NV; v++) begin
         cpu_op(VEC[v][18], VEC[v][17:8], VEC[v][7:0], rd);
         if (!VEC[v][18])
            chk(rd == VEC[v][7:0], "R8 table read data", rd, VEC[v][7:0]);
      end

      // R3: video read in its slot
      idle(4);
      to_slot(1'b1);
      vid_req = 1'b1; vid_addr = 10'h055;
      smp();
      chk(mem_en && !mem_we && mem_addr == 10'h055, "R3 video issue", mem_addr, 10'h055);
      nxt(); vid_req = 1'b0; smp();
      chk(vid_rvalid && vid_rdata == init_val(10'h055), "R3 video data",
          vid_rdata, init_val(10'h055));
      // R3: video request in CPU slot ignored
      to_slot(1'b0);
      vid_req = 1'b1; vid_addr = 10'h056;
      smp();
      chk(!mem_en, "R3 ignored access", mem_en, 0);
      nxt(); vid_req = 1'b0; smp();
      chk(!vid_rvalid, "R3 ignored valid", vid_rvalid, 0);

      // R10: idle CPU leaves memory untouched
      idle(4);
      for (int i = 0; i < 6; i++) begin
         smp();
         chk(!mem_en, "R10 idle memory", mem_en, 0);
         nxt();
      end

      // R5: write accepted in video slot drains in next cycle
      to_slot(1'b1);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h101; cpu_wdata = 8'h11;
      smp();
      chk(cpu_ready, "R5 immediate ready", cpu_ready, 1);
      chk(!mem_en, "R5 no write in video slot", mem_en, 0);
      nxt(); cpu_req = 1'b0; smp();
      chk(mem_we && mem_addr == 10'h101 && mem_wdata == 8'h11, "R5 drain next slot",
          mem_addr, 10'h101);
      // R5: write accepted in CPU slot drains two cycles later
      to_slot(1'b0);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h102; cpu_wdata = 8'h22;
      smp();
      chk(cpu_ready && !mem_en, "R5 accept in cpu slot", {cpu_ready, mem_en}, 2);
      nxt(); cpu_req = 1'b0; smp();
      chk(!mem_en, "R4 video slot no cpu write", mem_en, 0);
      nxt(); smp();
      chk(mem_we && mem_addr == 10'h102, "R5 later drain", mem_addr, 10'h102);

      // R6: second write meets full buffer
      idle(4);
      to_slot(1'b0);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h103; cpu_wdata = 8'h33;
      smp();
      chk(cpu_ready, "R6 first accepted", cpu_ready, 1);
      nxt(); cpu_addr = 10'h104; cpu_wdata = 8'h44; smp();
      chk(!cpu_ready, "R6 stall on full", cpu_ready, 0);
      nxt(); smp();
      chk(cpu_ready && mem_we && mem_addr == 10'h103, "R6 drain and accept",
          mem_addr, 10'h103);
      nxt(); cpu_req = 1'b0;

      // R7: read hits the buffered write
      idle(4);
      to_slot(1'b0);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h105; cpu_wdata = 8'h3C;
      smp();
      nxt(); cpu_we = 1'b0; smp();
      chk(cpu_ready && cpu_rdata == 8'h3C, "R7 buffer hit", cpu_rdata, 8'h3C);
      nxt(); cpu_req = 1'b0;

      // R8: miss with empty buffer, issued in the next CPU slot
      idle(4);
      to_slot(1'b1);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h120;
      smp();
      chk(!cpu_ready, "R8 wait for slot", cpu_ready, 0);
      nxt(); smp();
      chk(mem_en && !mem_we && mem_addr == 10'h120 && !cpu_ready, "R8 issue",
          mem_addr, 10'h120);
      nxt(); smp();
      chk(cpu_ready && cpu_rdata == init_val(10'h120), "R8 read data",
          cpu_rdata, init_val(10'h120));
      nxt(); cpu_req = 1'b0; smp();
      chk(!cpu_ready, "R9 no repeat", cpu_ready, 0);

      // R8: miss behind a pending write waits for the drain
      idle(4);
      to_slot(1'b1);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'h106; cpu_wdata = 8'h66;
      smp();
      nxt(); cpu_we = 1'b0; cpu_addr = 10'h130; smp();
      chk(!cpu_ready && mem_we && mem_addr == 10'h106, "R8 drain first",
          mem_addr, 10'h106);
      nxt(); smp();
      chk(!cpu_ready, "R8 still waiting", cpu_ready, 0);
      nxt(); smp();
      chk(mem_en && !mem_we && mem_addr == 10'h130, "R8 issue after drain",
          mem_addr, 10'h130);
      nxt(); smp();
      chk(cpu_ready && cpu_rdata == init_val(10'h130), "R8 late data",
          cpu_rdata, init_val(10'h130));
      nxt(); cpu_req = 1'b0;

      // reset in the middle of traffic returns to the video phase
      to_slot(1'b0);
      rst_n = 1'b0;
      nxt(); nxt();
      rst_n = 1'b1;
      smp();
      chk(vid_slot && !cpu_ready && !mem_en, "R1 re-reset", vid_slot, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule